// File: doc/BRIEF.md
# Start-Up Short-Circuit Protection Sequencer

This block is the control state machine behind an input protection switch. When its active-low enable is held low, it brings the pass switch up through a fixed ramp of discrete soft-start levels. At the end of the ramp it looks once at a current-limit flag supplied by the analog front end. If no limit is active, the switch settles into normal conduction and the clamp is dropped. If the limit is active, the sequencer holds the output current clamped for a bounded check window. If the overload outlasts that window, it walks the switch down through a soft-stop, pulls the fault line and waits out a recovery interval. It then begins the ramp again. This start/fail loop continues for as long as the overload persists.

A separate fault output drives the enable of an external open-drain pad; a high value means "pull the pad low". It asserts for the latched start-up short-circuit condition and for three live protection flags: input overvoltage, battery overvoltage and overtemperature. It asserts only while the block is enabled. Step length, check window and recovery interval are parameters counted in clock cycles. Analog sensing, gate drive and the pad itself sit outside the block.

Top module: `sc_guard_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it falls with `en_n` high, `ramp_level` is 0 and `sw_on`, `soft_stop`, `clamp_en` and `fault_pull` are all 0.
- R2: One clock edge after `en_n` is seen low from the off state, `ramp_level` becomes 1 and `sw_on` becomes 1. The level then rises by one every STEP_CYC cycles until it reaches STEPS (8). Each level is held exactly STEP_CYC cycles, with `clamp_en` low.
- R3: If `ilim_active` is low at the edge that ends the last ramp level, the block enters normal conduction on that edge. In that state `ramp_level` equals STEPS, `sw_on` is 1, and `clamp_en`, `soft_stop` and `fault_pull` are 0.
- R4: If `ilim_active` is high at that edge, a check window of CHK_CYC cycles follows. During the window `clamp_en` is 1, `sw_on` is 1, `ramp_level` equals STEPS, and `soft_stop` and `fault_pull` are 0.
- R5: If `ilim_active` is still high at the window's last edge, a soft-stop follows. `soft_stop` is 1 and the level steps down from STEPS to 1, each level held STEP_CYC cycles. `fault_pull` is 1 from the first soft-stop cycle onward.
- R6: After the soft-stop comes a recovery interval of REC_CYC cycles. During it `sw_on` is 0, `ramp_level` is 0 and `fault_pull` is 1. At its end the ramp restarts at level 1 with `fault_pull` released. Under a steady overload the loop repeats with a period of 2*STEPS*STEP_CYC + CHK_CYC + REC_CYC cycles.
- R7: If `ilim_active` is low at any edge inside the check window, the last one included, the block enters normal conduction on that edge.
- R8: Once in normal conduction, `ilim_active` has no effect: the outputs stay at the R3 values.
- R9: If the overload clears during a soft-stop or recovery, the next ramp ends in normal conduction.
- R10: While enabled, `fault_pull` follows, one edge later, the OR of the start-up short-circuit condition and the three live flags `in_ovp`, `bat_ovp`, `over_temp`.
- R11: `en_n` high forces, on the next edge and from any state, all outputs to 0 with `fault_pull` released whatever the flags. A later low `en_n` restarts the ramp from level 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_n | input | 1 | Active-low enable; high turns the switch off |
| ilim_active | input | 1 | Current limit is presently limiting the output |
| in_ovp | input | 1 | Input overvoltage flag |
| bat_ovp | input | 1 | Battery overvoltage flag |
| over_temp | input | 1 | Overtemperature flag |
| ramp_level | output | LVL_W ($clog2(STEPS+1), 4 by default) | Soft-start/soft-stop drive level, 0 = off |
| sw_on | output | 1 | Pass switch conduction command |
| soft_stop | output | 1 | Soft-stop in progress |
| clamp_en | output | 1 | Hold output current at the short-circuit clamp level |
| fault_pull | output | 1 | Enable for the open-drain fault pad (1 = pull low) |

## Verification
The bench sweeps the check window by releasing the current limit at every possible offset, including the final edge. A design that tested the timer before the flag would soft-stop there instead of conducting. It walks a persistent overload through soft-stop, recovery and restart, and measures the loop period, which exposes off-by-one timer reloads and any check that fires again after normal conduction begins. It also sweeps all eight combinations of the protection flags with the block enabled and disabled. It breaks off the sequence in mid-ramp and in mid-soft-stop, which catches fault gating that ignores the enable and restarts that resume at a stale level.

// File: rtl/sc_seq_pkg.sv
package sc_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_RAMP    = 3'd1,
    ST_CHECK   = 3'd2,
    ST_STOP    = 3'd3,
    ST_RECOVER = 3'd4,
    ST_RUN     = 3'd5
  } phase_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sc_phase_timer.sv
module sc_phase_timer #(
  parameter int CNT_W    = 8,
  parameter int MAX_LOAD = 255
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

  // R2
  timer_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(MAX_LOAD));

endmodule

// File: rtl/sc_fault_merge.sv
module sc_fault_merge (
  input  logic clk,
  input  logic rst,
  input  logic en_n,
  input  logic sc_next,
  input  logic in_ovp,
  input  logic bat_ovp,
  input  logic over_temp,
  output logic fault_pull
);

  logic any_fault;
  logic fault_q;

  assign any_fault = sc_next | in_ovp | bat_ovp | over_temp;

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_q <= 1'b0;
    end else begin
      fault_q <= ~en_n & any_fault;
    end
  end

  assign fault_pull = fault_q;

endmodule

// File: rtl/sc_phase_fsm.sv
module sc_phase_fsm
  import sc_seq_pkg::*;
#(
  parameter int STEPS    = 8,
  parameter int STEP_CYC = 4,
  parameter int CHK_CYC  = 8,
  parameter int REC_CYC  = 8,
  parameter int CNT_W    = 4,
  parameter int LVL_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_n,
  input  logic             ilim_active,
  input  logic             tmr_done,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic [LVL_W-1:0] ramp_level,
  output logic             sw_on,
  output logic             soft_stop,
  output logic             clamp_en,
  output logic             sc_next
);

  localparam logic [CNT_W-1:0] STEP_LOAD = CNT_W'(STEP_CYC - 1);
  localparam logic [CNT_W-1:0] CHK_LOAD  = CNT_W'(CHK_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LOAD  = CNT_W'(REC_CYC - 1);
  localparam logic [LVL_W-1:0] LVL_TOP   = LVL_W'(STEPS);
  localparam logic [LVL_W-1:0] LVL_ONE   = LVL_W'(1);

  phase_e           state_q, nxt_state;
  logic [LVL_W-1:0] level_q, nxt_level;
  logic             sw_on_q, soft_stop_q, clamp_q;

  always_comb begin
    nxt_state = state_q;
    nxt_level = level_q;
    tmr_load  = 1'b0;
    tmr_val   = STEP_LOAD;
    case (state_q)
      ST_OFF: begin
        nxt_state = ST_RAMP;
        nxt_level = LVL_ONE;
        tmr_load  = 1'b1;
      end
      ST_RAMP: begin
        if (tmr_done) begin
          if (level_q < LVL_TOP) begin
            nxt_level = level_q + 1'b1;
            tmr_load  = 1'b1;
          end else if (ilim_active) begin
            nxt_state = ST_CHECK;
            tmr_load  = 1'b1;
            tmr_val   = CHK_LOAD;
          end else begin
            nxt_state = ST_RUN;
          end
        end
      end
      ST_CHECK: begin
        if (!ilim_active) begin
          nxt_state = ST_RUN;
        end else if (tmr_done) begin
          nxt_state = ST_STOP;
          tmr_load  = 1'b1;
        end
      end
      ST_STOP: begin
        if (tmr_done) begin
          if (level_q > LVL_ONE) begin
            nxt_level = level_q - 1'b1;
            tmr_load  = 1'b1;
          end else begin
            nxt_state = ST_RECOVER;
            nxt_level = '0;
            tmr_load  = 1'b1;
            tmr_val   = REC_LOAD;
          end
        end
      end
      ST_RECOVER: begin
        if (tmr_done) begin
          nxt_state = ST_RAMP;
          nxt_level = LVL_ONE;
          tmr_load  = 1'b1;
        end
      end
      ST_RUN: begin
        nxt_state = ST_RUN;
      end
      default: begin
        nxt_state = ST_OFF;
        nxt_level = '0;
      end
    endcase
    if (en_n) begin
      nxt_state = ST_OFF;
      nxt_level = '0;
    end
  end

  assign sc_next = (nxt_state == ST_STOP) || (nxt_state == ST_RECOVER);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_OFF;
      level_q     <= '0;
      sw_on_q     <= 1'b0;
      soft_stop_q <= 1'b0;
      clamp_q     <= 1'b0;
    end else begin
      state_q     <= nxt_state;
      level_q     <= nxt_level;
      sw_on_q     <= (nxt_state == ST_RAMP) || (nxt_state == ST_CHECK) ||
                     (nxt_state == ST_STOP) || (nxt_state == ST_RUN);
      soft_stop_q <= (nxt_state == ST_STOP);
      clamp_q     <= (nxt_state == ST_CHECK) || (nxt_state == ST_STOP);
    end
  end

  assign ramp_level = level_q;
  assign sw_on      = sw_on_q;
  assign soft_stop  = soft_stop_q;
  assign clamp_en   = clamp_q;

  // R2
  level_le_max_chk: assert property (@(posedge clk) disable iff (rst)
    level_q <= LVL_TOP);

  // R8
  run_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(state_q) == ST_RUN) && !$past(en_n)) |-> (state_q == ST_RUN));

  // R5
  stop_starts_full_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(soft_stop_q) |-> (level_q == LVL_TOP));

  // R4
  clamp_needs_switch_chk: assert property (@(posedge clk) disable iff (rst)
    clamp_q |-> sw_on_q);

endmodule

// File: rtl/sc_guard_seq.sv
module sc_guard_seq
  import sc_seq_pkg::*;
#(
  parameter int STEPS    = 8,
  parameter int STEP_CYC = 1000,
  parameter int CHK_CYC  = 500000,
  parameter int REC_CYC  = 6000000,
  localparam int LVL_W   = $clog2(STEPS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_n,
  input  logic             ilim_active,
  input  logic             in_ovp,
  input  logic             bat_ovp,
  input  logic             over_temp,
  output logic [LVL_W-1:0] ramp_level,
  output logic             sw_on,
  output logic             soft_stop,
  output logic             clamp_en,
  output logic             fault_pull
);

  localparam int CNT_MAX = max3(STEP_CYC, CHK_CYC, REC_CYC) - 1;
  localparam int CNT_W   = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX + 1);

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_done;
  logic             sc_next;

  sc_phase_timer #(
    .CNT_W    (CNT_W),
    .MAX_LOAD (CNT_MAX)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  sc_phase_fsm #(
    .STEPS    (STEPS),
    .STEP_CYC (STEP_CYC),
    .CHK_CYC  (CHK_CYC),
    .REC_CYC  (REC_CYC),
    .CNT_W    (CNT_W),
    .LVL_W    (LVL_W)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .en_n        (en_n),
    .ilim_active (ilim_active),
    .tmr_done    (tmr_done),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .ramp_level  (ramp_level),
    .sw_on       (sw_on),
    .soft_stop   (soft_stop),
    .clamp_en    (clamp_en),
    .sc_next     (sc_next)
  );

  sc_fault_merge u_fault (
    .clk        (clk),
    .rst        (rst),
    .en_n       (en_n),
    .sc_next    (sc_next),
    .in_ovp     (in_ovp),
    .bat_ovp    (bat_ovp),
    .over_temp  (over_temp),
    .fault_pull (fault_pull)
  );

  // R5
  stop_flags_fault_chk: assert property (@(posedge clk) disable iff (rst)
    soft_stop |-> fault_pull);

  // R11
  disable_off_chk: assert property (@(posedge clk) disable iff (rst)
    $past(en_n) |-> (!sw_on && !fault_pull && !clamp_en));

endmodule

// File: tb/sc_guard_seq_bench.sv
module sc_guard_seq_bench;

  localparam int ST = 8;
  localparam int S  = 3;
  localparam int C  = 5;
  localparam int R  = 4;
  localparam int LW = $clog2(ST + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en_n = 1'b1;
  logic          ilim_active = 1'b0;
  logic          in_ovp = 1'b0;
  logic          bat_ovp = 1'b0;
  logic          over_temp = 1'b0;
  logic [LW-1:0] ramp_level;
  logic          sw_on, soft_stop, clamp_en, fault_pull;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  sc_guard_seq #(
    .STEPS    (ST),
    .STEP_CYC (S),
    .CHK_CYC  (C),
    .REC_CYC  (R)
  ) u_sc_guard_seq (
    .clk         (clk),
    .rst         (rst),
    .en_n        (en_n),
    .ilim_active (ilim_active),
    .in_ovp      (in_ovp),
    .bat_ovp     (bat_ovp),
    .over_temp   (over_temp),
    .ramp_level  (ramp_level),
    .sw_on       (sw_on),
    .soft_stop   (soft_stop),
    .clamp_en    (clamp_en),
    .fault_pull  (fault_pull)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // packed view: {level, sw_on, soft_stop, clamp_en, fault_pull}
  function automatic int outs();
    return {ramp_level, sw_on, soft_stop, clamp_en, fault_pull};
  endfunction

  function automatic int pack(input int lvl, input bit sw, input bit ss,
                              input bit cl, input bit fl);
    return {LW'(lvl), sw, ss, cl, fl};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; en_n = 1'b1; ilim_active = 1'b0;
    in_ovp = 1'b0; bat_ovp = 1'b0; over_temp = 1'b0;
    wait_n(2);
    rst = 1'b0;
    wait_n(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cnt;
    // ---------- R1 reset state
    @(negedge clk);
    chk("R1 in reset", outs(), pack(0, 0, 0, 0, 0));
    do_reset();
    chk("R1 after reset", outs(), pack(0, 0, 0, 0, 0));

    // ---------- R2/R3 clean start, then R8 overload ignored in run
    en_n = 1'b0;
    for (int s = 1; s <= ST; s++)
      for (int c = 0; c < S; c++) begin
        wait_n(1);
        chk("R2 ramp level", outs(), pack(s, 1, 0, 0, 0));
      end
    wait_n(1);
    chk("R3 normal after ramp", outs(), pack(ST, 1, 0, 0, 0));
    ilim_active = 1'b1;
    for (int i = 0; i < 3 * C; i++) begin
      wait_n(1);
      chk("R8 run ignores limit", outs(), pack(ST, 1, 0, 0, 0));
    end

    // ---------- R4/R5/R6 persistent overload loop, then R9 clear
    do_reset();
    ilim_active = 1'b1;
    en_n = 1'b0;
    wait_n(ST * S);
    chk("R4 last ramp step", outs(), pack(ST, 1, 0, 0, 0));
    for (int k = 0; k < C; k++) begin
      wait_n(1);
      chk("R4 check window", outs(), pack(ST, 1, 0, 1, 0));
    end
    for (int lv = ST; lv >= 1; lv--)
      for (int c = 0; c < S; c++) begin
        wait_n(1);
        chk("R5 soft-stop", outs(), pack(lv, 1, 1, 1, 1));
      end
    for (int c = 0; c < R; c++) begin
      wait_n(1);
      chk("R6 recovery", outs(), pack(0, 0, 0, 0, 1));
    end
    wait_n(1);
    chk("R6 restart", outs(), pack(1, 1, 0, 0, 0));
    cnt = 0;
    while (!soft_stop && cnt < 4 * ST * S + C + R) begin
      wait_n(1);
      cnt++;
    end
    chk("R6 loop period", cnt + ST * S + R, 2 * ST * S + C + R);
    ilim_active = 1'b0;
    wait_n(ST * S - 1);
    chk("R9 stop continues", outs(), pack(1, 1, 1, 1, 1));
    wait_n(R);
    chk("R9 recovery end", outs(), pack(0, 0, 0, 0, 1));
    wait_n(ST * S);
    chk("R9 retry ramp top", outs(), pack(ST, 1, 0, 0, 0));
    wait_n(S + 1);
    chk("R9 normal after clear", outs(), pack(ST, 1, 0, 0, 0));

    // ---------- R7 early release at every offset in the window
    for (int k = 1; k <= C; k++) begin
      do_reset();
      ilim_active = 1'b1;
      en_n = 1'b0;
      wait_n(ST * S + k);
      chk("R7 in window", clamp_en, 1);
      ilim_active = 1'b0;
      wait_n(1);
      chk("R7 release to run", outs(), pack(ST, 1, 0, 0, 0));
      wait_n(C + S);
      chk("R7 run stays", outs(), pack(ST, 1, 0, 0, 0));
    end

    // ---------- R10/R11 flag sweep enabled and disabled
    do_reset();
    en_n = 1'b0;
    wait_n(ST * S + 1);
    for (int f = 0; f < 8; f++) begin
      {in_ovp, bat_ovp, over_temp} = 3'(f);
      wait_n(1);
      chk("R10 flag OR", fault_pull, (f != 0) ? 1 : 0);
      chk("R10 switch unaffected", sw_on, 1);
    end
    en_n = 1'b1;
    for (int f = 0; f < 8; f++) begin
      {in_ovp, bat_ovp, over_temp} = 3'(f);
      wait_n(1);
      chk("R11 disabled flags", outs(), pack(0, 0, 0, 0, 0));
    end
    in_ovp = 1'b0; bat_ovp = 1'b0; over_temp = 1'b0;

    // ---------- R11 disable mid-ramp and mid-stop
    do_reset();
    ilim_active = 1'b1;
    en_n = 1'b0;
    wait_n(4 * S + 1);
    chk("R11 mid ramp level", ramp_level, 5);
    en_n = 1'b1;
    wait_n(1);
    chk("R11 off from ramp", outs(), pack(0, 0, 0, 0, 0));
    en_n = 1'b0;
    wait_n(1);
    chk("R11 restart at 1", outs(), pack(1, 1, 0, 0, 0));
    do_reset();
    ilim_active = 1'b1;
    en_n = 1'b0;
    wait_n(ST * S + C + 2);
    chk("R11 in soft-stop", soft_stop, 1);
    en_n = 1'b1;
    wait_n(1);
    chk("R11 off from stop", outs(), pack(0, 0, 0, 0, 0));

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule